// File: doc/BRIEF.md
# Serial Port FIFO Trigger Flags

This block holds the two byte queues of a serial port and produces the two service flags that software and interrupt logic watch. The first flag is transmit room, which signals that the outgoing queue has drained far enough to take another burst. The second is receive ready, which signals that the incoming queue has filled far enough to be worth emptying. Both queues are 16 entries of 8 bits. The bit shifter is not part of the block. A `tx_pop` strobe takes the oldest outgoing byte, and an `rx_push` strobe delivers an incoming byte.

Each flag is a sticky register that is set by comparing a fill level against a programmable trigger count. The comparison runs every cycle and uses the fill count that results from that cycle's push and pop. Software clears a flag by first reading it as 1 and then writing 0 to its bit. If the level condition still holds in the cycle of the clear, the set wins and the flag reads 1 again at once. A small register port gives the host the data window, the status flags, the trigger selects and both live fill counts.

Top module: `sff_flag_core`

## Requirements
- R1: After reset, status reads 0x01 (transmit room set, receive ready clear, overflow clear), control reads 0, and both count registers read 0.
- R2: Bytes written to address 0 leave on `tx_byte` in write order, and each `tx_pop` removes the head. A `tx_pop` while the transmit queue is empty changes nothing.
- R3: A write to address 0 while the transmit queue holds 16 bytes is dropped and sets status bit 2 (overflow). Overflow stays set until a status write with bit 2 equal to 0.
- R4: Control bits [1:0] select the transmit trigger: code 0 selects 8, code 1 selects 4, code 2 selects 2 and code 3 selects 0. Status bit 0 becomes 1 in the same cycle that the transmit count becomes less than or equal to the trigger.
- R5: Control bits [3:2] select the receive trigger: code 0 selects 1, code 1 selects 4, code 2 selects 8 and code 3 selects 14. Status bit 1 becomes 1 in the same cycle that the receive count becomes greater than or equal to the trigger.
- R6: A status write with a flag bit equal to 0 clears that flag only if a status read returned that flag as 1 after the previous status write. Writing 1 to a flag bit has no effect.
- R7: A clear is overridden when the flag's level condition holds in the clear cycle, so the flag reads 1 on the next access.
- R8: A flag that has been set stays 1 after its level condition stops holding, until an effective clear.
- R9: Address 3 reads the transmit count and address 4 reads the receive count, each from 0 to 16, and both update in the cycle of the push or pop.
- R10: `rx_push` stores `rx_byte` unless the receive queue is full, in which case the byte is dropped. A read of address 0 returns the oldest received byte and removes it. A read of address 0 with the queue empty returns 0.
- R11: Control bits [3:0] read back at address 2 exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (a read of address 0 pops the receive queue) |
| host_addr | input | 3 | Register address: 0 data, 1 status, 2 control, 3 transmit count, 4 receive count |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the addressed register |
| tx_pop | input | 1 | Shifter takes the head transmit byte |
| tx_byte | output | 8 | Head of the transmit queue |
| tx_nonempty | output | 1 | Transmit queue holds at least one byte |
| rx_push | input | 1 | Shifter delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_full | output | 1 | Receive queue holds 16 bytes |
| txroom_flag | output | 1 | Transmit room flag (same as status bit 0) |
| rxready_flag | output | 1 | Receive ready flag (same as status bit 1) |

## Verification
The assertions assume that the host raises at most one of `host_wr` and `host_rd` in a cycle, and that these strobes and the shifter strobes are stable across each rising edge. The bench drives every strobe on the falling edge and runs one host access per cycle. The clear-arming checks assume that a status read and a status write never happen in the same cycle, and the stimulus always separates the arming read from the clearing write. The stimulus walks each trigger code through the full range from 0 to 16 entries, so that every comparison boundary is crossed in both queues.

// File: rtl/sff_pkg.sv
package sff_pkg;

   localparam int unsigned SFF_AW = 3;
   localparam int unsigned SFF_DW = 8;

   typedef enum logic [SFF_AW-1:0] {
      SFF_A_DATA  = 3'd0,
      SFF_A_STAT  = 3'd1,
      SFF_A_CTRL  = 3'd2,
      SFF_A_TXCNT = 3'd3,
      SFF_A_RXCNT = 3'd4
   } sff_addr_e;

   localparam int unsigned SFF_ST_TXROOM = 0;
   localparam int unsigned SFF_ST_RXRDY  = 1;
   localparam int unsigned SFF_ST_OVF    = 2;

   typedef struct packed {
      logic [1:0] rx_code;
      logic [1:0] tx_code;
   } sff_ctrl_t;

   function automatic int unsigned sff_tx_level(input logic [1:0] code);
      case (code)
         2'd0:    return 8;
         2'd1:    return 4;
         2'd2:    return 2;
         default: return 0;
      endcase
   endfunction

   function automatic int unsigned sff_rx_level(input logic [1:0] code);
      case (code)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 14;
      endcase
   endfunction

endpackage

// File: rtl/sff_fifo.sv
module sff_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned PW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic [CW-1:0] count_nxt,
   output logic          full,
   output logic          empty
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sff_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [PW-1:0] wr_ptr_q, rd_ptr_q;
   logic [CW-1:0] count_q;
   logic          push_ok, pop_ok;
   logic [W-1:0]  words [DEPTH];

   assign full    = (count_q == CW'(DEPTH));
   assign empty   = (count_q == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;

   assign count_nxt = count_q + CW'(push_ok) - CW'(pop_ok);
   assign count     = count_q;

   generate
      for (genvar i = 0; i < int'(DEPTH); i++) begin : g_slot
         logic [W-1:0] slot_q;
         always_ff @(posedge clk) begin
            if (push_ok && wr_ptr_q == PW'(i)) begin
               slot_q <= din;
            end
         end
         assign words[i] = slot_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (push_ok) wr_ptr_q <= wr_ptr_q + PW'(1);
         if (pop_ok)  rd_ptr_q <= rd_ptr_q + PW'(1);
         count_q <= count_nxt;
      end
   end

   assign dout = empty ? '0 : words[rd_ptr_q];

   // R9: the fill count never exceeds the depth
   a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CW'(DEPTH));

   // R3 / R10: a push into a full queue without a pop leaves the count alone
   a_r3_full_push_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> $stable(count_q));

   // R2: a pop from an empty queue without a push leaves it empty
   a_r2_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> (count_q == '0));

endmodule

// File: rtl/sff_trig_flag.sv
module sff_trig_flag #(
   parameter int unsigned CW      = 5,
   parameter bit          AT_ABOVE = 1'b0,
   parameter bit          RST_VAL  = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] level,
   input  logic [CW-1:0] trig,
   input  logic          stat_rd,
   input  logic          stat_wr,
   input  logic          wbit,
   output logic          flag
);

   logic meet;
   logic flag_q, armed_q;
   logic clr_eff;

   generate
      if (AT_ABOVE) begin : g_above
         assign meet = (level >= trig);
      end else begin : g_below
         assign meet = (level <= trig);
      end
   endgenerate

   assign clr_eff = stat_wr && !wbit && armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= RST_VAL;
         armed_q <= 1'b0;
      end else begin
         flag_q  <= meet | (flag_q & ~clr_eff);
         armed_q <= (armed_q & ~stat_wr) | (stat_rd & flag_q);
      end
   end

   assign flag = flag_q;

   // R7: when the level condition holds, the flag is 1 next cycle even if cleared
   a_r7_level_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ((AT_ABOVE && level >= trig) || (!AT_ABOVE && level <= trig)) |=> flag_q);

   // R6: without a prior read as 1, a status write cannot drop the flag
   a_r6_unarmed_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !armed_q) |=> flag_q);

   // R8: with no status write the flag is sticky
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !stat_wr) |=> flag_q);

endmodule

// File: rtl/sff_flag_core.sv
module sff_flag_core #(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned DW   = sff_pkg::SFF_DW,
   localparam int unsigned AW   = sff_pkg::SFF_AW,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_wr,
   input  logic          host_rd,
   input  logic [AW-1:0] host_addr,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata,
   input  logic          tx_pop,
   output logic [DW-1:0] tx_byte,
   output logic          tx_nonempty,
   input  logic          rx_push,
   input  logic [DW-1:0] rx_byte,
   output logic          rx_full,
   output logic          txroom_flag,
   output logic          rxready_flag
);
   import sff_pkg::*;

   generate
      if (DEPTH < 15) begin : g_bad_depth
         $error("sff_flag_core: DEPTH must hold the largest receive trigger");
      end
      if (CW > DW) begin : g_bad_width
         $error("sff_flag_core: count does not fit a data word");
      end
   endgenerate

   logic          sel_data, sel_stat, sel_ctrl;
   logic          data_wr, data_rd, stat_wr, stat_rd, ctrl_wr;
   sff_ctrl_t     ctrl_q;
   logic          ovf_q;
   logic [CW-1:0] tx_cnt, tx_cnt_nxt, rx_cnt, rx_cnt_nxt;
   logic [CW-1:0] tx_trig, rx_trig;
   logic          tx_full, tx_empty, rx_empty;
   logic [DW-1:0] rx_head;

   assign sel_data = (host_addr == SFF_A_DATA);
   assign sel_stat = (host_addr == SFF_A_STAT);
   assign sel_ctrl = (host_addr == SFF_A_CTRL);
   assign data_wr  = host_wr && sel_data;
   assign data_rd  = host_rd && sel_data;
   assign stat_wr  = host_wr && sel_stat;
   assign stat_rd  = host_rd && sel_stat;
   assign ctrl_wr  = host_wr && sel_ctrl;

   sff_fifo #(.W(DW), .DEPTH(DEPTH)) u_tx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (data_wr),
      .din       (host_wdata),
      .pop       (tx_pop),
      .dout      (tx_byte),
      .count     (tx_cnt),
      .count_nxt (tx_cnt_nxt),
      .full      (tx_full),
      .empty     (tx_empty)
   );

   sff_fifo #(.W(DW), .DEPTH(DEPTH)) u_rx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rx_push),
      .din       (rx_byte),
      .pop       (data_rd),
      .dout      (rx_head),
      .count     (rx_cnt),
      .count_nxt (rx_cnt_nxt),
      .full      (rx_full),
      .empty     (rx_empty)
   );

   assign tx_nonempty = !tx_empty;

   assign tx_trig = CW'(sff_tx_level(ctrl_q.tx_code));
   assign rx_trig = CW'(sff_rx_level(ctrl_q.rx_code));

   sff_trig_flag #(.CW(CW), .AT_ABOVE(1'b0), .RST_VAL(1'b1)) u_tx_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .level   (tx_cnt_nxt),
      .trig    (tx_trig),
      .stat_rd (stat_rd),
      .stat_wr (stat_wr),
      .wbit    (host_wdata[SFF_ST_TXROOM]),
      .flag    (txroom_flag)
   );

   sff_trig_flag #(.CW(CW), .AT_ABOVE(1'b1), .RST_VAL(1'b0)) u_rx_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .level   (rx_cnt_nxt),
      .trig    (rx_trig),
      .stat_rd (stat_rd),
      .stat_wr (stat_wr),
      .wbit    (host_wdata[SFF_ST_RXRDY]),
      .flag    (rxready_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         if (ctrl_wr) ctrl_q <= sff_ctrl_t'(host_wdata[3:0]);
         if (data_wr && tx_full) begin
            ovf_q <= 1'b1;
         end else if (stat_wr && !host_wdata[SFF_ST_OVF]) begin
            ovf_q <= 1'b0;
         end
      end
   end

   always_comb begin
      host_rdata = '0;
      case (host_addr)
         SFF_A_DATA:  host_rdata = rx_head;
         SFF_A_STAT: begin
            host_rdata[SFF_ST_TXROOM] = txroom_flag;
            host_rdata[SFF_ST_RXRDY]  = rxready_flag;
            host_rdata[SFF_ST_OVF]    = ovf_q;
         end
         SFF_A_CTRL:  host_rdata[3:0] = ctrl_q;
         SFF_A_TXCNT: host_rdata = DW'(tx_cnt);
         SFF_A_RXCNT: host_rdata = DW'(rx_cnt);
         default:     host_rdata = '0;
      endcase
   end

   // R3: a write into a full transmit queue raises overflow
   a_r3_full_write_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && tx_full) |=> ovf_q);

   // R3: overflow holds until a status write with bit 2 low
   a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !(stat_wr && !host_wdata[SFF_ST_OVF])) |=> ovf_q);

   // R11: control holds its value unless written
   a_r11_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |=> $stable(ctrl_q));

endmodule

// File: tb/sff_flag_core_tb.sv
module sff_flag_core_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0, host_rd = 1'b0;
   logic [2:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       tx_pop = 1'b0;
   logic [7:0] tx_byte;
   logic       tx_nonempty;
   logic       rx_push = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       rx_full;
   logic       txroom_flag, rxready_flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] tx_q[$];
   logic [7:0] rx_q[$];
   int         tx_n = 0, rx_n = 0;
   logic [7:0] seed = 8'h30;

   always #5 clk = ~clk;

   sff_flag_core dut_i (
      .clk(clk), .rst_n(rst_n),
      .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_nonempty(tx_nonempty),
      .rx_push(rx_push), .rx_byte(rx_byte), .rx_full(rx_full),
      .txroom_flag(txroom_flag), .rxready_flag(rxready_flag)
   );

   function automatic int tx_lvl(input int code);
      case (code) 0: return 8; 1: return 4; 2: return 2; default: return 0; endcase
   endfunction
   function automatic int rx_lvl(input int code);
      case (code) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
      host_rd = 1'b1; host_addr = a;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic check_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
      logic [7:0] d;
      reg_rd(a, d);
      chk(req, d, exp);
   endtask

   // driver: push expected transmit bytes into the scoreboard
   task automatic tx_write;
      reg_wr(3'd0, seed);
      if (tx_n < 16) begin tx_q.push_back(seed); tx_n++; end
      seed = seed + 8'd7;
   endtask

   // monitor side: compare the head against the scoreboard as it leaves
   task automatic tx_take;
      logic [7:0] e;
      if (tx_n > 0) begin
         e = tx_q.pop_front();
         chk("R2 tx order", tx_byte, e);
         tx_n--;
      end
      tx_pop = 1'b1;
      @(negedge clk);
      tx_pop = 1'b0;
   endtask

   task automatic rx_in(input logic [7:0] b);
      rx_push = 1'b1; rx_byte = b;
      @(negedge clk);
      rx_push = 1'b0;
      if (rx_n < 16) begin rx_q.push_back(b); rx_n++; end
   endtask

   task automatic rx_take;
      logic [7:0] d, e;
      reg_rd(3'd0, d);
      if (rx_n > 0) begin
         e = rx_q.pop_front();
         rx_n--;
      end else e = 8'h00;
      chk("R10 rx read", d, e);
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] d;
      logic ex;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check_reg("R1 status", 3'd1, 8'h01);
      check_reg("R1 ctrl",   3'd2, 8'h00);
      check_reg("R1 txcnt",  3'd3, 8'h00);
      check_reg("R1 rxcnt",  3'd4, 8'h00);

      // trigger 8: nine bytes, flag stays set (R8)
      for (int k = 0; k < 9; k++) tx_write();
      check_reg("R9 txcnt 9", 3'd3, 8'd9);
      check_reg("R8 sticky", 3'd1, 8'h01);
      reg_wr(3'd1, 8'h07);            // writing 1s: no clear, disarms
      check_reg("R6 write one", 3'd1, 8'h01);
      reg_wr(3'd1, 8'h07);
      reg_wr(3'd1, 8'h00);            // no read since last write: ignored
      check_reg("R6 unarmed", 3'd1, 8'h01);
      reg_wr(3'd1, 8'h00);            // armed by the read above
      check_reg("R6 clear", 3'd1, 8'h00);
      tx_take();                      // 9 -> 8
      check_reg("R4 set at 8", 3'd1, 8'h01);
      reg_wr(3'd1, 8'h00);
      check_reg("R7 reassert", 3'd1, 8'h01);
      while (tx_n > 0) tx_take();
      tx_take();                      // pop on empty
      check_reg("R2 empty pop", 3'd3, 8'h00);

      // every transmit trigger code
      for (int c = 0; c < 4; c++) begin
         reg_wr(3'd2, 8'(c));
         check_reg("R11 ctrl", 3'd2, 8'(c));
         while (tx_n < 16) tx_write();
         tx_write();                  // dropped
         check_reg("R3 drop count", 3'd3, 8'd16);
         check_reg("R3 ovf set", 3'd1, 8'h05);
         reg_wr(3'd1, 8'h00);         // clear flag and overflow
         check_reg("R3 ovf clear", 3'd1, 8'h00);
         ex = 1'b0;
         while (tx_n > 0) begin
            tx_take();
            if (tx_n <= tx_lvl(c)) ex = 1'b1;
            check_reg("R4 tx trigger", 3'd1, {7'b0, ex});
         end
      end

      // every receive trigger code
      for (int c = 0; c < 4; c++) begin
         reg_wr(3'd2, 8'(c << 2));
         check_reg("R11 ctrl rx", 3'd2, 8'(c << 2));
         ex = 1'b0;
         for (int k = 0; k < 16; k++) begin
            rx_in(8'hA0 + 8'(k) + 8'(c * 16));
            if (rx_n >= rx_lvl(c)) ex = 1'b1;
            check_reg("R5 rx trigger", 3'd1, {6'b0, ex, 1'b1});
         end
         rx_in(8'h5A);                // dropped
         check_reg("R10 rx full drop", 3'd4, 8'd16);
         reg_rd(3'd1, d);
         reg_wr(3'd1, 8'h00);
         check_reg("R7 rx reassert", 3'd1, 8'h03);
         while (rx_n > 0) rx_take();
         rx_take();                   // empty read returns 0
         check_reg("R9 rxcnt 0", 3'd4, 8'h00);
         check_reg("R8 rx sticky", 3'd1, 8'h03);
         reg_wr(3'd1, 8'h00);
         check_reg("R6 rx clear", 3'd1, 8'h01);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule